// File: doc/BRIEF.md
# Saturating Threshold Event Counter

This block keeps a single count of a configurable width. External logic moves the count with two active-high strobes, one for up and one for down. Each direction has its own step size. A step is either a fixed build-time constant or a value taken from a dedicated input whose width is a parameter. When both strobes arrive in the same cycle, their steps are combined into one net change that is applied in a single update.

Each direction can optionally clamp at a bound. The upper bound defaults to all ones and the lower bound to zero. When clamping is off, the count wraps modulo two to the width, and the block raises a one-cycle pulse to flag the wrap. A comparator watches the count against a programmable threshold and holds a flag high while the count is at or above it.

Software loads the count through a write strobe with data, and reads it back on the count output. A software write wins over any hardware strobe in the same cycle.

Top module: `sat_evt_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes RESET_VAL (default 0) and both wrap pulses become 0.
- R2: With `inc_i` high and no write, the count grows by the up step at the clock edge. With INC_FROM_PORT=1 the up step is `inc_step_i`, zero-extended; otherwise it is the parameter INC_FIXED.
- R3: With `dec_i` high and no write, the count falls by the down step, chosen the same way from `dec_step_i` or DEC_FIXED.
- R4: With both strobes high, the count changes by the up step minus the down step in one update. Equal steps leave the count unchanged and raise no pulse.
- R5: With `up_sat_en_i` high, an upward net change whose result would exceed UP_LIMIT leaves the count at UP_LIMIT, and `ovf_o` stays 0.
- R6: With `dn_sat_en_i` high, a downward net change whose result would drop below LO_LIMIT leaves the count at LO_LIMIT, and `udf_o` stays 0.
- R7: With up clamping off, an upward change past 2^CNT_W-1 leaves the result modulo 2^CNT_W. `ovf_o` is then high for exactly the one cycle after that edge.
- R8: With down clamping off, a downward change below 0 leaves the result modulo 2^CNT_W. `udf_o` is then high for exactly the one cycle after that edge.
- R9: `thr_hit_o` is 1 exactly while the count is greater than or equal to `thr_i`, both read as unsigned.
- R10: When `sw_we_i` is high, the count loads `sw_wdata_i` regardless of the strobes, and no wrap pulse follows.
- R11: A count held at a clamp bound stays there under further strobes in the same direction, and no wrap pulse is raised.
- R12: With no strobe and no write, the count holds and no wrap pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | 1 | Up strobe |
| inc_step_i | input | STEP_W | Up step value |
| dec_i | input | 1 | Down strobe |
| dec_step_i | input | STEP_W | Down step value |
| up_sat_en_i | input | 1 | Clamp at the upper bound instead of wrapping |
| dn_sat_en_i | input | 1 | Clamp at the lower bound instead of wrapping |
| thr_i | input | CNT_W | Threshold value |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | CNT_W | Software write data |
| count_o | output | CNT_W | Current count |
| thr_hit_o | output | 1 | Count is at or above the threshold |
| ovf_o | output | 1 | One-cycle upward wrap pulse |
| udf_o | output | 1 | One-cycle downward wrap pulse |

## Verification
The bench targets the bounds. It steps onto and past non-default clamp limits, and drives the count through the top and the bottom of its range with clamping off. A design that tests the clamp against the full range instead of the limit would climb past the upper bound. A design that tests wraps on the truncated sum would miss a pulse or land on the wrong value.

Simultaneous strobes with equal steps catch a design that applies the two directions in turn and flags a spurious wrap. A write issued together with an active strobe catches lost write priority. Threshold probes one below and exactly at the threshold catch a comparison that is off by one.

// File: rtl/sec_pkg.sv
package sec_pkg;

    typedef enum logic [1:0] {
        WK_NONE  = 2'd0,
        WK_OVER  = 2'd1,
        WK_UNDER = 2'd2
    } wrap_e;

    typedef struct packed {
        logic ovf;
        logic udf;
    } wrap_flags_t;

    function automatic wrap_flags_t flags_of(input wrap_e k);
        wrap_flags_t f;
        f.ovf = (k == WK_OVER);
        f.udf = (k == WK_UNDER);
        return f;
    endfunction

endpackage

// File: rtl/sec_step_sel.sv
module sec_step_sel #(
    parameter int          STEP_W    = 4,
    parameter bit          FROM_PORT = 1'b1,
    parameter logic [STEP_W-1:0] FIXED = '0
) (
    input  logic              strobe_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [STEP_W-1:0] step_o
);
    generate
        if (FROM_PORT) begin : g_port
            assign step_o = strobe_i ? step_i : '0;
        end else begin : g_fixed
            logic [STEP_W-1:0] unused_step;
            assign unused_step = step_i;
            assign step_o = strobe_i ? FIXED : '0;
        end
    endgenerate
endmodule

// File: rtl/sec_next_calc.sv
module sec_next_calc
    import sec_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int STEP_W = 4,
    parameter logic [CNT_W-1:0] UP_LIMIT = '1,
    parameter logic [CNT_W-1:0] LO_LIMIT = '0
) (
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [STEP_W-1:0] add_i,
    input  logic [STEP_W-1:0] sub_i,
    input  logic              up_sat_en_i,
    input  logic              dn_sat_en_i,
    output logic [CNT_W-1:0]  nxt_o,
    output wrap_e             kind_o
);
    localparam int EW = CNT_W + 2;
    localparam logic signed [EW-1:0] TOP_S = {2'b00, {CNT_W{1'b1}}};
    localparam logic signed [EW-1:0] UPL_S = {2'b00, UP_LIMIT};
    localparam logic signed [EW-1:0] LOL_S = {2'b00, LO_LIMIT};

    logic signed [EW-1:0] cnt_s, add_s, sub_s, sum_s;

    assign cnt_s = {2'b00, cnt_i};
    assign add_s = {{(EW-STEP_W){1'b0}}, add_i};
    assign sub_s = {{(EW-STEP_W){1'b0}}, sub_i};
    assign sum_s = cnt_s + add_s - sub_s;

    always_comb begin
        nxt_o  = sum_s[CNT_W-1:0];
        kind_o = WK_NONE;
        if (add_i > sub_i) begin
            if (up_sat_en_i && (sum_s > UPL_S)) begin
                nxt_o = UP_LIMIT;
            end else if (sum_s > TOP_S) begin
                kind_o = WK_OVER;
            end
        end else if (sub_i > add_i) begin
            if (dn_sat_en_i && (sum_s < LOL_S)) begin
                nxt_o = LO_LIMIT;
            end else if (sum_s < 0) begin
                kind_o = WK_UNDER;
            end
        end
    end
endmodule

// File: rtl/sec_thr_cmp.sv
module sec_thr_cmp #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             hit_o
);
    assign hit_o = (cnt_i >= thr_i);
endmodule

// File: rtl/sat_evt_counter.sv
module sat_evt_counter
    import sec_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int STEP_W = 4,
    parameter bit INC_FROM_PORT = 1'b1,
    parameter bit DEC_FROM_PORT = 1'b1,
    parameter logic [STEP_W-1:0] INC_FIXED = 1,
    parameter logic [STEP_W-1:0] DEC_FIXED = 1,
    parameter logic [CNT_W-1:0]  UP_LIMIT  = '1,
    parameter logic [CNT_W-1:0]  LO_LIMIT  = '0,
    parameter logic [CNT_W-1:0]  RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_i,
    input  logic [STEP_W-1:0] inc_step_i,
    input  logic              dec_i,
    input  logic [STEP_W-1:0] dec_step_i,
    input  logic              up_sat_en_i,
    input  logic              dn_sat_en_i,
    input  logic [CNT_W-1:0]  thr_i,
    input  logic              sw_we_i,
    input  logic [CNT_W-1:0]  sw_wdata_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              thr_hit_o,
    output logic              ovf_o,
    output logic              udf_o
);
    logic [STEP_W-1:0] add_w, sub_w;
    logic [CNT_W-1:0]  nxt_w;
    wrap_e             kind_w;
    wrap_flags_t       flags_w;

    logic [CNT_W-1:0]  cnt_q;
    wrap_flags_t       wrap_q;

    sec_step_sel #(.STEP_W(STEP_W), .FROM_PORT(INC_FROM_PORT), .FIXED(INC_FIXED)) u_inc_sel (
        .strobe_i (inc_i),
        .step_i   (inc_step_i),
        .step_o   (add_w)
    );

    sec_step_sel #(.STEP_W(STEP_W), .FROM_PORT(DEC_FROM_PORT), .FIXED(DEC_FIXED)) u_dec_sel (
        .strobe_i (dec_i),
        .step_i   (dec_step_i),
        .step_o   (sub_w)
    );

    sec_next_calc #(.CNT_W(CNT_W), .STEP_W(STEP_W), .UP_LIMIT(UP_LIMIT), .LO_LIMIT(LO_LIMIT)) u_calc (
        .cnt_i       (cnt_q),
        .add_i       (add_w),
        .sub_i       (sub_w),
        .up_sat_en_i (up_sat_en_i),
        .dn_sat_en_i (dn_sat_en_i),
        .nxt_o       (nxt_w),
        .kind_o      (kind_w)
    );

    assign flags_w = flags_of(kind_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= RESET_VAL;
            wrap_q <= '0;
        end else if (sw_we_i) begin
            cnt_q  <= sw_wdata_i;
            wrap_q <= '0;
        end else begin
            cnt_q  <= nxt_w;
            wrap_q <= flags_w;
        end
    end

    sec_thr_cmp #(.CNT_W(CNT_W)) u_thr (
        .cnt_i (cnt_q),
        .thr_i (thr_i),
        .hit_o (thr_hit_o)
    );

    assign count_o = cnt_q;
    assign ovf_o   = wrap_q.ovf;
    assign udf_o   = wrap_q.udf;
endmodule

// File: rtl/sec_chk.sv
module sec_chk #(
    parameter int CNT_W = 8,
    parameter logic [CNT_W-1:0] UP_LIMIT = '1,
    parameter logic [CNT_W-1:0] LO_LIMIT = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             inc_i,
    input logic             dec_i,
    input logic             up_sat_en_i,
    input logic             dn_sat_en_i,
    input logic             sw_we_i,
    input logic [CNT_W-1:0] sw_wdata_i,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_o,
    input logic             udf_o
);
    // R5
    up_sat_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> !$past(up_sat_en_i));

    // R6
    dn_sat_no_udf_chk: assert property (@(posedge clk) disable iff (rst)
        udf_o |-> !$past(dn_sat_en_i));

    // R7 R8
    wrap_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ovf_o && udf_o));

    // R10
    sw_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sw_we_i)) |-> (count_o == $past(sw_wdata_i) && !ovf_o && !udf_o));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!inc_i && !dec_i && !sw_we_i)) |-> ($stable(count_o) && !ovf_o && !udf_o));

    // R11
    up_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(up_sat_en_i && inc_i && !dec_i && !sw_we_i && count_o == UP_LIMIT))
            |-> (count_o == UP_LIMIT));

    // R11
    dn_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dn_sat_en_i && dec_i && !inc_i && !sw_we_i && count_o == LO_LIMIT))
            |-> (count_o == LO_LIMIT));
endmodule

bind sat_evt_counter sec_chk #(.CNT_W(CNT_W), .UP_LIMIT(UP_LIMIT), .LO_LIMIT(LO_LIMIT)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .inc_i       (inc_i),
    .dec_i       (dec_i),
    .up_sat_en_i (up_sat_en_i),
    .dn_sat_en_i (dn_sat_en_i),
    .sw_we_i     (sw_we_i),
    .sw_wdata_i  (sw_wdata_i),
    .count_o     (count_o),
    .ovf_o       (ovf_o),
    .udf_o       (udf_o)
);

// File: tb/sat_evt_counter_tb_top.sv
`timescale 1ns/1ps
module sat_evt_counter_tb_top;
    localparam int CNT_W  = 8;
    localparam int STEP_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inc_i = 0, dec_i = 0, up_sat_en_i = 0, dn_sat_en_i = 0, sw_we_i = 0;
    logic [STEP_W-1:0] inc_step_i = '0, dec_step_i = '0;
    logic [CNT_W-1:0]  thr_i = 8'd100, sw_wdata_i = '0;
    logic [CNT_W-1:0]  count_o;
    logic thr_hit_o, ovf_o, udf_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    sat_evt_counter #(
        .CNT_W(CNT_W), .STEP_W(STEP_W),
        .UP_LIMIT(8'd200), .LO_LIMIT(8'd10)
    ) dut_i (
        .clk(clk), .rst(rst),
        .inc_i(inc_i), .inc_step_i(inc_step_i),
        .dec_i(dec_i), .dec_step_i(dec_step_i),
        .up_sat_en_i(up_sat_en_i), .dn_sat_en_i(dn_sat_en_i),
        .thr_i(thr_i), .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
        .count_o(count_o), .thr_hit_o(thr_hit_o), .ovf_o(ovf_o), .udf_o(udf_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; applies inputs over one rising edge, returns at next falling edge.
    task automatic step(input logic inc, input int is, input logic dec, input int ds,
                        input logic we, input int wd);
        inc_i = inc; inc_step_i = is[STEP_W-1:0];
        dec_i = dec; dec_step_i = ds[STEP_W-1:0];
        sw_we_i = we; sw_wdata_i = wd[CNT_W-1:0];
        @(posedge clk);
        @(negedge clk);
        inc_i = 0; dec_i = 0; sw_we_i = 0;
    endtask

    task automatic load(input int v);
        step(0, 0, 0, 0, 1, v);
    endtask

    task automatic t_reset();
        check("R1 count", count_o, 0);
        check("R1 ovf", ovf_o, 0);
        check("R1 udf", udf_o, 0);
    endtask

    task automatic t_inc_dec();
        up_sat_en_i = 0; dn_sat_en_i = 0;
        load(50);
        step(1, 5, 0, 0, 0, 0);   check("R2 inc5", count_o, 55);
        step(1, 15, 0, 0, 0, 0);  check("R2 inc15", count_o, 70);
        step(0, 0, 1, 7, 0, 0);   check("R3 dec7", count_o, 63);
    endtask

    task automatic t_both();
        step(1, 9, 1, 4, 0, 0);   check("R4 net", count_o, 68);
        step(1, 3, 1, 3, 0, 0);   check("R4 equal", count_o, 68);
        check("R4 no ovf", ovf_o, 0);
        check("R4 no udf", udf_o, 0);
    endtask

    task automatic t_thr();
        load(99);                  check("R9 below", thr_hit_o, 0);
        step(1, 1, 0, 0, 0, 0);    check("R9 equal", thr_hit_o, 1);
        step(1, 1, 0, 0, 0, 0);    check("R9 above", thr_hit_o, 1);
        step(0, 0, 1, 2, 0, 0);    check("R9 back below", thr_hit_o, 0);
    endtask

    task automatic t_wrap();
        up_sat_en_i = 0; dn_sat_en_i = 0;
        load(250);
        step(1, 10, 0, 0, 0, 0);
        check("R7 wrap value", count_o, 4);
        check("R7 ovf pulse", ovf_o, 1);
        check("R7 no udf", udf_o, 0);
        step(0, 0, 0, 0, 0, 0);
        check("R12 hold", count_o, 4);
        check("R7 pulse ends", ovf_o, 0);
        load(195);
        step(1, 15, 0, 0, 0, 0);
        check("R7 past limit, no clamp", count_o, 210);
        check("R7 no ovf below top", ovf_o, 0);
        load(3);
        step(0, 0, 1, 5, 0, 0);
        check("R8 wrap value", count_o, 254);
        check("R8 udf pulse", udf_o, 1);
        step(0, 0, 0, 0, 0, 0);
        check("R8 pulse ends", udf_o, 0);
    endtask

    task automatic t_up_sat();
        up_sat_en_i = 1;
        load(195);
        step(1, 4, 0, 0, 0, 0);   check("R5 below limit", count_o, 199);
        step(1, 4, 0, 0, 0, 0);   check("R5 clamp", count_o, 200);
        check("R5 no ovf", ovf_o, 0);
        step(1, 15, 0, 0, 0, 0);  check("R11 pinned up", count_o, 200);
        check("R11 no ovf", ovf_o, 0);
        load(250);
        step(1, 15, 0, 0, 0, 0);  check("R5 clamp over top", count_o, 200);
        check("R5 no ovf over top", ovf_o, 0);
        up_sat_en_i = 0;
    endtask

    task automatic t_dn_sat();
        dn_sat_en_i = 1;
        load(14);
        step(0, 0, 1, 3, 0, 0);   check("R6 above limit", count_o, 11);
        step(0, 0, 1, 3, 0, 0);   check("R6 clamp", count_o, 10);
        check("R6 no udf", udf_o, 0);
        step(0, 0, 1, 15, 0, 0);  check("R11 pinned down", count_o, 10);
        check("R11 no udf", udf_o, 0);
        dn_sat_en_i = 0;
    endtask

    task automatic t_sw();
        load(60);
        step(1, 15, 0, 0, 1, 77); check("R10 write beats inc", count_o, 77);
        step(0, 0, 1, 9, 1, 0);   check("R10 write beats dec", count_o, 0);
        check("R10 no udf", udf_o, 0);
        load(255);
        step(1, 15, 0, 0, 1, 255); check("R10 no ovf", ovf_o, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 0;
        t_inc_dec();
        t_both();
        t_thr();
        t_wrap();
        t_up_sat();
        t_dn_sat();
        t_sw();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule